// File: doc/BRIEF.md
# Line-Termination Activation Controller

This block steers one subscriber line of a 4B3T line-termination transceiver through power-up, wake-up, synchronisation and shut-down. It reads a 4-bit command code from the command channel, three line-side status levels (wake tone heard, receiver locked, remote terminal locked) and three test pins. From these it selects what the transmitter sends and which 4-bit indication code goes back upstream. Four timers of 0.5, 1, 7 and 12 ms pace the sequence. One timer runs at a time, and a one-cycle tick input counts their time.

Three overrides (reset, single-pulse test, forced transparent) take the machine out of any state. Each can come from a command code or from a pin. After an override, only a local-loop activation request brings the line back into the normal cycle. All inputs are plain levels: the command code is held for as long as it is meant. No stream interface exists, so there is no back-pressure. Indications are combinational in the state and the live receiver-lock level.

Top module: `lt_act_ctrl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, the machine is in the Reset state. `ind` is DEAC (4'b0001), `tx_sel` is quiet (0) and `line_pulse` is 0.
- R2: `res_pin` high or command 4'b1101 puts the machine in Reset at the next edge, from any state. This wins over every other input. Reset indicates DEAC with `tx_sel` quiet.
- R3: If R2 does not apply, `ssp_pin` high or command 4'b0101 enters the Test state. This wins over the forced-transparent inputs. Test indicates DEAC with `tx_sel` single-pulse (4). `line_pulse` strobes for one cycle once every 1 ms timer period for as long as the machine stays in Test.
- R4: If neither R2 nor R3 applies, `dt_pin` high or command 4'b0110 forces Transparent. Transparent indicates AI (4'b1100) while `sync_ok` is high and RSY (4'b0100) while it is low, with `tx_sel` data (3).
- R5: In Reset or Test, command AR1 (4'b1001) moves to Deactivating. Every other non-override command leaves the state and the indication unchanged.
- R6: Command DR (4'b0000) in any state from wake-up through Transparent moves to Deactivating. Deactivating indicates DEAC and runs the 0.5 ms timer. On expiry the machine goes to Deactivation Acknowledge, which indicates DI (4'b1111).
- R7: In Deactivation Acknowledge, command DC (4'b1111) moves to Deactivated, which still indicates DI with `tx_sel` quiet.
- R8: In Deactivated, any of AR (4'b1000), AR1, AR2 (4'b1010) or AR4 (4'b1011) starts the 12 ms timer and enters Awaking. Awaking indicates AR (4'b1000) and sends the wake tone (`tx_sel` 1). `awake_rx` alone in Deactivated enters Awake-Acknowledge.
- R9: In Awaking, `awake_rx` moves to Awake-Acknowledge unless the request was AR1. On 12 ms expiry the machine goes straight to Synchronising if the request was AR1, otherwise to Awake-Sent (quiet, AR), which waits for `awake_rx`. Awake-Acknowledge sends the wake tone for 7 ms, then enters Synchronising (`tx_sel` training 2, AR).
- R10: In Synchronising, `sync_ok` moves to Linked (data, UAI 4'b0111, RSY if `sync_ok` drops). With `sync_ok` high and either `rt_sync` high or an AR1 request, Linked starts the 1 ms timer. On expiry the machine enters Transparent.
- R11: Each timer lasts N ticks (N = 1, 2, 14, 24 times `HALF_MS_TICKS`). Ticks counted begin at the first edge after the start edge. Expiry is a one-cycle event in the cycle after the N-th counted tick. It acts at the following edge, and any override cancels it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer time-base strobe, one per 0.5 ms / HALF_MS_TICKS |
| cmd | input | 4 | Command code from the command channel, held as a level |
| res_pin | input | 1 | Reset override pin, active high |
| ssp_pin | input | 1 | Single-pulse test pin, active high |
| dt_pin | input | 1 | Forced-transparent pin, active high |
| awake_rx | input | 1 | Wake tone detected from the far end |
| sync_ok | input | 1 | Local receiver synchronised |
| rt_sync | input | 1 | Remote terminal reports synchronised |
| ind | output | 4 | Upstream indication code |
| tx_sel | output | 3 | Transmit selection: 0 quiet, 1 wake, 2 training, 3 data, 4 single pulse |
| line_pulse | output | 1 | One-cycle strobe for each single test pulse |

## Verification
The bench goes after override collisions: all three overrides raised at once must give Reset, and test plus transparent together must give Test. A design with the priority inverted lands in the wrong state and shows pulses or AI where DEAC and quiet are expected. Both ends of the 12 ms timer are exercised, with and without the local-loop request. A design that drops the remembered AR1 waits in Awake-Sent instead of training, and one that reverses the wake-tone condition acknowledges a loop activation. The loss of `sync_ok` in Linked and Transparent is checked for the RSY code. Single-pulse spacing is checked against the 1 ms period, so an off-by-one timer reload shows up as a drifting pulse count. A cycle model that follows each timer tick by tick catches a timer that expires one tick early or late, or that keeps running past an override.

// File: rtl/lt_act_pkg.sv
package lt_act_pkg;

  typedef enum logic [3:0] {
    S_RESET, S_TEST, S_DEACTING, S_DEAC_ACK, S_DEACTED, S_AWAKING,
    S_AWAKE_SENT, S_AWAKE_ACK, S_SYNCING, S_LINKED, S_WAIT1, S_TRANSP
  } lt_state_e;

  typedef enum logic [1:0] {TM_T05, TM_T1, TM_T7, TM_T12} tmr_sel_e;
  typedef enum logic [1:0] {OV_NONE, OV_RES, OV_SSP, OV_DT} ovr_e;
  typedef enum logic [2:0] {TX_QUIET, TX_WAKE, TX_TRAIN, TX_DATA, TX_PULSE} tx_e;

  localparam logic [3:0] CMD_DR  = 4'b0000;
  localparam logic [3:0] CMD_SSP = 4'b0101;
  localparam logic [3:0] CMD_DT  = 4'b0110;
  localparam logic [3:0] CMD_AR  = 4'b1000;
  localparam logic [3:0] CMD_AR1 = 4'b1001;
  localparam logic [3:0] CMD_AR2 = 4'b1010;
  localparam logic [3:0] CMD_AR4 = 4'b1011;
  localparam logic [3:0] CMD_RES = 4'b1101;
  localparam logic [3:0] CMD_DC  = 4'b1111;

  localparam logic [3:0] IND_DEAC = 4'b0001;
  localparam logic [3:0] IND_RSY  = 4'b0100;
  localparam logic [3:0] IND_UAI  = 4'b0111;
  localparam logic [3:0] IND_AR   = 4'b1000;
  localparam logic [3:0] IND_AI   = 4'b1100;
  localparam logic [3:0] IND_DI   = 4'b1111;

  // Timer length in half-millisecond units, indexed by tmr_sel_e
  function automatic int unsigned tmr_halves(input int idx);
    case (idx)
      0:       return 1;
      1:       return 2;
      2:       return 14;
      default: return 24;
    endcase
  endfunction

endpackage

// File: rtl/lt_act_cmd_dec.sv
module lt_act_cmd_dec
  import lt_act_pkg::*;
(
  input  logic [3:0] cmd,
  input  logic       res_pin,
  input  logic       ssp_pin,
  input  logic       dt_pin,
  output ovr_e       ovr,
  output logic       is_dr,
  output logic       is_dc,
  output logic       is_ar_any,
  output logic       is_ar1
);

  always_comb begin
    if (res_pin || cmd == CMD_RES)      ovr = OV_RES;
    else if (ssp_pin || cmd == CMD_SSP) ovr = OV_SSP;
    else if (dt_pin || cmd == CMD_DT)   ovr = OV_DT;
    else                                ovr = OV_NONE;
  end

  assign is_dr     = (cmd == CMD_DR);
  assign is_dc     = (cmd == CMD_DC);
  assign is_ar1    = (cmd == CMD_AR1);
  assign is_ar_any = (cmd == CMD_AR) || (cmd == CMD_AR1) ||
                     (cmd == CMD_AR2) || (cmd == CMD_AR4);

endmodule

// File: rtl/lt_act_timer.sv
module lt_act_timer
  import lt_act_pkg::*;
#(
  parameter int HALF_MS_TICKS = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     start,
  input  logic     stop,
  input  tmr_sel_e sel,
  output logic     expired
);

  localparam int NTMR = 4;
  localparam int MAXT = 24 * HALF_MS_TICKS;
  localparam int CW   = $clog2(MAXT + 1);

  logic [CW-1:0] preset [NTMR];
  logic [CW-1:0] cnt_q;
  logic          run_q;

  for (genvar g = 0; g < NTMR; g++) begin : g_preset
    assign preset[g] = CW'(tmr_halves(g) * HALF_MS_TICKS);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      run_q   <= 1'b0;
      expired <= 1'b0;
    end else if (start) begin
      cnt_q   <= preset[sel];
      run_q   <= 1'b1;
      expired <= 1'b0;
    end else if (stop) begin
      run_q   <= 1'b0;
      expired <= 1'b0;
    end else begin
      expired <= 1'b0;
      if (run_q && tick) begin
        if (cnt_q == CW'(1)) begin
          run_q   <= 1'b0;
          expired <= 1'b1;
        end else begin
          cnt_q <= cnt_q - CW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/lt_act_fsm.sv
module lt_act_fsm
  import lt_act_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  ovr_e      ovr,
  input  logic      is_dr,
  input  logic      is_dc,
  input  logic      is_ar_any,
  input  logic      is_ar1,
  input  logic      awake_rx,
  input  logic      sync_ok,
  input  logic      rt_sync,
  input  logic      tmr_exp,
  output logic      tmr_start,
  output logic      tmr_stop,
  output tmr_sel_e  tmr_sel,
  output lt_state_e st,
  output logic [3:0] ind,
  output tx_e       tx,
  output logic      line_pulse
);

  lt_state_e nxt;
  logic      loop_q;

  // Next-state selection: overrides first, then per-state rules
  always_comb begin
    nxt = st;
    unique case (ovr)
      OV_RES:  nxt = S_RESET;
      OV_SSP:  nxt = S_TEST;
      OV_DT:   nxt = S_TRANSP;
      default: begin
        case (st)
          S_RESET, S_TEST: if (is_ar1) nxt = S_DEACTING;
          S_DEACTING:      if (tmr_exp) nxt = S_DEAC_ACK;
          S_DEAC_ACK:      if (is_dc) nxt = S_DEACTED;
          S_DEACTED: begin
            if (is_ar_any)     nxt = S_AWAKING;
            else if (awake_rx) nxt = S_AWAKE_ACK;
          end
          S_AWAKING: begin
            if (is_dr)                    nxt = S_DEACTING;
            else if (awake_rx && !loop_q) nxt = S_AWAKE_ACK;
            else if (tmr_exp)             nxt = loop_q ? S_SYNCING : S_AWAKE_SENT;
          end
          S_AWAKE_SENT: begin
            if (is_dr)         nxt = S_DEACTING;
            else if (awake_rx) nxt = S_AWAKE_ACK;
          end
          S_AWAKE_ACK: begin
            if (is_dr)        nxt = S_DEACTING;
            else if (tmr_exp) nxt = S_SYNCING;
          end
          S_SYNCING: begin
            if (is_dr)        nxt = S_DEACTING;
            else if (sync_ok) nxt = S_LINKED;
          end
          S_LINKED: begin
            if (is_dr)                             nxt = S_DEACTING;
            else if (sync_ok && (rt_sync || loop_q)) nxt = S_WAIT1;
          end
          S_WAIT1: begin
            if (is_dr)        nxt = S_DEACTING;
            else if (tmr_exp) nxt = S_TRANSP;
          end
          S_TRANSP: if (is_dr) nxt = S_DEACTING;
          default: nxt = S_RESET;
        endcase
      end
    endcase
  end

  // Timer control: start on entry to a timed state, stop on entry to others
  always_comb begin
    tmr_start = 1'b0;
    tmr_stop  = 1'b0;
    tmr_sel   = TM_T1;
    if (nxt != st) begin
      case (nxt)
        S_DEACTING:  begin tmr_start = 1'b1; tmr_sel = TM_T05; end
        S_AWAKING:   begin tmr_start = 1'b1; tmr_sel = TM_T12; end
        S_AWAKE_ACK: begin tmr_start = 1'b1; tmr_sel = TM_T7;  end
        S_WAIT1:     begin tmr_start = 1'b1; tmr_sel = TM_T1;  end
        S_TEST:      begin tmr_start = 1'b1; tmr_sel = TM_T1;  end
        default:     tmr_stop = 1'b1;
      endcase
    end else if (st == S_TEST && tmr_exp) begin
      tmr_start = 1'b1;
      tmr_sel   = TM_T1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_RESET;
      loop_q <= 1'b0;
    end else begin
      st <= nxt;
      if (st == S_DEACTED && nxt != S_DEACTED)
        loop_q <= is_ar1 && (nxt == S_AWAKING);
    end
  end

  // Per-state indication and transmit selection
  always_comb begin
    case (st)
      S_RESET, S_DEACTING:    begin ind = IND_DEAC; tx = TX_QUIET; end
      S_TEST:                 begin ind = IND_DEAC; tx = TX_PULSE; end
      S_DEAC_ACK, S_DEACTED:  begin ind = IND_DI;   tx = TX_QUIET; end
      S_AWAKING, S_AWAKE_ACK: begin ind = IND_AR;   tx = TX_WAKE;  end
      S_AWAKE_SENT:           begin ind = IND_AR;   tx = TX_QUIET; end
      S_SYNCING:              begin ind = IND_AR;   tx = TX_TRAIN; end
      S_LINKED, S_WAIT1:      begin ind = sync_ok ? IND_UAI : IND_RSY; tx = TX_DATA; end
      S_TRANSP:               begin ind = sync_ok ? IND_AI : IND_RSY;  tx = TX_DATA; end
      default:                begin ind = IND_DEAC; tx = TX_QUIET; end
    endcase
  end

  assign line_pulse = (st == S_TEST) && tmr_exp;

endmodule

// File: rtl/lt_act_ctrl.sv
module lt_act_ctrl
  import lt_act_pkg::*;
#(
  parameter int HALF_MS_TICKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [3:0] cmd,
  input  logic       res_pin,
  input  logic       ssp_pin,
  input  logic       dt_pin,
  input  logic       awake_rx,
  input  logic       sync_ok,
  input  logic       rt_sync,
  output logic [3:0] ind,
  output logic [2:0] tx_sel,
  output logic       line_pulse
);

  ovr_e      ovr;
  logic      is_dr, is_dc, is_ar_any, is_ar1;
  logic      tmr_start, tmr_stop, tmr_exp;
  tmr_sel_e  tmr_sel;
  lt_state_e st;
  tx_e       tx;

  lt_act_cmd_dec u_dec (
    .cmd(cmd), .res_pin(res_pin), .ssp_pin(ssp_pin), .dt_pin(dt_pin),
    .ovr(ovr), .is_dr(is_dr), .is_dc(is_dc), .is_ar_any(is_ar_any), .is_ar1(is_ar1)
  );

  lt_act_timer #(.HALF_MS_TICKS(HALF_MS_TICKS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(tmr_start), .stop(tmr_stop),
    .sel(tmr_sel), .expired(tmr_exp)
  );

  lt_act_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .ovr(ovr), .is_dr(is_dr), .is_dc(is_dc),
    .is_ar_any(is_ar_any), .is_ar1(is_ar1), .awake_rx(awake_rx), .sync_ok(sync_ok),
    .rt_sync(rt_sync), .tmr_exp(tmr_exp), .tmr_start(tmr_start), .tmr_stop(tmr_stop),
    .tmr_sel(tmr_sel), .st(st), .ind(ind), .tx(tx), .line_pulse(line_pulse)
  );

  assign tx_sel = tx;

endmodule

// File: rtl/lt_act_ctrl_chk.sv
module lt_act_ctrl_chk
  import lt_act_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] cmd,
  input logic       res_pin,
  input logic       ssp_pin,
  input logic       dt_pin,
  input logic [2:0] tx_sel,
  input logic       line_pulse,
  input lt_state_e  st,
  input logic       tmr_exp
);

  logic res_on, ssp_on, dt_on;
  assign res_on = res_pin || cmd == CMD_RES;
  assign ssp_on = ssp_pin || cmd == CMD_SSP;
  assign dt_on  = dt_pin || cmd == CMD_DT;

  a_r2_res_wins: assert property (@(posedge clk) disable iff (!rst_n)
    res_on |=> st == S_RESET);

  a_r3_ssp_over_dt: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_on && ssp_on) |=> st == S_TEST);

  a_r4_dt_forces_transp: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_on && !ssp_on && dt_on) |=> st == S_TRANSP);

  a_r3_pulse_only_in_test: assert property (@(posedge clk) disable iff (!rst_n)
    line_pulse |-> tx_sel == 3'd4);

  a_r6_ack_from_deact: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DEAC_ACK && $past(st) != S_DEAC_ACK) |-> $past(st) == S_DEACTING);

  a_r11_expiry_single: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_exp |=> !tmr_exp);

endmodule

bind lt_act_ctrl lt_act_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .res_pin(res_pin), .ssp_pin(ssp_pin),
  .dt_pin(dt_pin), .tx_sel(tx_sel), .line_pulse(line_pulse), .st(st), .tmr_exp(tmr_exp)
);

// File: tb/lt_act_ctrl_bench.sv
module lt_act_ctrl_bench;

  localparam int CLK_P = 10;
  localparam int HMS   = 2;
  localparam int TDIV  = 4;

  // Model state numbering (bench-own)
  localparam int M_RST = 0, M_TST = 1, M_DCG = 2, M_DAK = 3, M_DCD = 4, M_AWK = 5,
                 M_AWS = 6, M_AAK = 7, M_SYN = 8, M_LNK = 9, M_W1 = 10, M_TRN = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [3:0] cmd = 4'b0010;
  logic res_pin = 0, ssp_pin = 0, dt_pin = 0, awake_rx = 0, sync_ok = 0, rt_sync = 0;
  logic [3:0] ind;
  logic [2:0] tx_sel;
  logic line_pulse;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  int  m_st = M_RST, m_rem = 0;
  bit  m_run = 0, m_exp = 0, m_loop = 0;

  always #(CLK_P/2) clk = ~clk;

  lt_act_ctrl #(.HALF_MS_TICKS(HMS)) u_lt_act_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd(cmd), .res_pin(res_pin),
    .ssp_pin(ssp_pin), .dt_pin(dt_pin), .awake_rx(awake_rx), .sync_ok(sync_ok),
    .rt_sync(rt_sync), .ind(ind), .tx_sel(tx_sel), .line_pulse(line_pulse)
  );

  function automatic int dur_of(int s);
    case (s)
      M_DCG:   return 1 * HMS;
      M_AWK:   return 24 * HMS;
      M_AAK:   return 14 * HMS;
      M_W1, M_TST: return 2 * HMS;
      default: return 0;
    endcase
  endfunction

  function automatic int model_next(int s);
    bit ar_any;
    ar_any = cmd inside {4'b1000, 4'b1001, 4'b1010, 4'b1011};
    if (res_pin || cmd == 4'b1101) return M_RST;
    if (ssp_pin || cmd == 4'b0101) return M_TST;
    if (dt_pin || cmd == 4'b0110)  return M_TRN;
    if (s >= M_AWK && cmd == 4'b0000) return M_DCG;
    case (s)
      M_RST, M_TST: return (cmd == 4'b1001) ? M_DCG : s;
      M_DCG: return m_exp ? M_DAK : s;
      M_DAK: return (cmd == 4'b1111) ? M_DCD : s;
      M_DCD: return ar_any ? M_AWK : (awake_rx ? M_AAK : s);
      M_AWK: begin
        if (awake_rx && !m_loop) return M_AAK;
        if (m_exp) return m_loop ? M_SYN : M_AWS;
        return s;
      end
      M_AWS: return awake_rx ? M_AAK : s;
      M_AAK: return m_exp ? M_SYN : s;
      M_SYN: return sync_ok ? M_LNK : s;
      M_LNK: return (sync_ok && (rt_sync || m_loop)) ? M_W1 : s;
      M_W1:  return m_exp ? M_TRN : s;
      default: return s;
    endcase
  endfunction

  function automatic logic [3:0] exp_ind(int s);
    case (s)
      M_RST, M_TST, M_DCG: return 4'b0001;
      M_DAK, M_DCD:        return 4'b1111;
      M_AWK, M_AWS, M_AAK, M_SYN: return 4'b1000;
      M_LNK, M_W1:         return sync_ok ? 4'b0111 : 4'b0100;
      default:             return sync_ok ? 4'b1100 : 4'b0100;
    endcase
  endfunction

  function automatic logic [2:0] exp_tx(int s);
    case (s)
      M_TST:        return 3'd4;
      M_AWK, M_AAK: return 3'd1;
      M_SYN:        return 3'd2;
      M_LNK, M_W1, M_TRN: return 3'd3;
      default:      return 3'd0;
    endcase
  endfunction

  function automatic string tag_of(int s);
    case (s)
      M_RST: return "R2";  M_TST: return "R3";  M_DCG, M_DAK: return "R6";
      M_DCD: return "R7";  M_AWK: return "R8";  M_AWS, M_AAK, M_SYN: return "R9";
      M_LNK: return "R10"; M_W1: return "R11";  default: return "R4";
    endcase
  endfunction

  // Reference model, updated on the same edge as the design
  always @(posedge clk) begin
    int ns;
    if (!rst_n) begin
      m_st <= M_RST; m_run <= 0; m_exp <= 0; m_loop <= 0; m_rem <= 0;
    end else begin
      ns = model_next(m_st);
      if (m_st == M_DCD && ns != M_DCD) m_loop <= (ns == M_AWK) && (cmd == 4'b1001);
      if ((ns != m_st && dur_of(ns) != 0) || (ns == m_st && m_st == M_TST && m_exp)) begin
        m_rem <= dur_of(ns); m_run <= 1; m_exp <= 0;
      end else if (ns != m_st) begin
        m_run <= 0; m_exp <= 0;
      end else begin
        m_exp <= 0;
        if (m_run && tick) begin
          if (m_rem == 1) begin m_run <= 0; m_exp <= 1; end
          else m_rem <= m_rem - 1;
        end
      end
      m_st <= ns;
    end
  end

  task automatic check(string req, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, expv, cyc);
    end
  endtask

  // One clock: compare outputs a quarter period after the edge, then advance the tick
  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #(CLK_P/4);
      cyc++;
      if (rst_n) begin
        check(tag_of(m_st), "ind", ind, exp_ind(m_st));
        check(tag_of(m_st), "tx_sel", tx_sel, exp_tx(m_st));
        check("R3", "line_pulse", line_pulse, (m_st == M_TST) && m_exp);
      end
      tick = (cyc % TDIV) == 0;
    end
  endtask

  task automatic idle_inputs();
    cmd = 4'b0010; res_pin = 0; ssp_pin = 0; dt_pin = 0;
    awake_rx = 0; sync_ok = 0; rt_sync = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; step(3); rst_n = 1; idle_inputs();
    step(1);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=0", 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int pulses;
    void'($urandom(32'd4711));
    idle_inputs();
    do_reset();
    // R1: reset state
    check("R1", "ind after reset", ind, 4'b0001);
    check("R1", "tx after reset", tx_sel, 0);
    check("R1", "pulse after reset", line_pulse, 0);

    // R5: non-AR1 commands ignored in Reset
    cmd = 4'b1000; step(20);
    check("R5", "ind ignores AR in reset", ind, 4'b0001);
    cmd = 4'b1001; step(2);
    check("R5", "AR1 leaves reset, DEAC", ind, 4'b0001);
    cmd = 4'b0010; step(20);
    check("R6", "DI after T05", ind, 4'b1111);
    cmd = 4'b1111; step(3);
    check("R7", "deactivated DI", ind, 4'b1111);
    cmd = 4'b1000; step(2);
    check("R8", "awaking ind", ind, 4'b1000);
    check("R8", "awaking tx", tx_sel, 1);
    cmd = 4'b0010; step(220);
    check("R9", "awake-sent quiet after T12", tx_sel, 0);
    awake_rx = 1; step(2);
    check("R9", "awake ack tone", tx_sel, 1);
    awake_rx = 0; step(130);
    check("R9", "training after T7", tx_sel, 2);
    sync_ok = 1; step(2);
    check("R10", "linked UAI", ind, 4'b0111);
    rt_sync = 1; step(25);
    check("R10", "transparent AI", ind, 4'b1100);
    sync_ok = 0; step(1);
    check("R4", "transparent RSY on lost sync", ind, 4'b0100);
    cmd = 4'b0000; step(2);
    check("R6", "DR deactivates", ind, 4'b0001);
    cmd = 4'b0010; step(20);
    check("R6", "DI after DR", ind, 4'b1111);

    // Local loop path through AR1
    cmd = 4'b1111; step(2);
    cmd = 4'b1001; step(2);
    cmd = 4'b0010; awake_rx = 1; step(20);
    check("R9", "loop ignores wake tone", tx_sel, 1);
    awake_rx = 0; step(200);
    check("R9", "loop goes to training on T12", tx_sel, 2);
    sync_ok = 1; rt_sync = 0; step(30);
    check("R10", "loop reaches transparent", ind, 4'b1100);

    // Override priority
    res_pin = 1; ssp_pin = 1; dt_pin = 1; step(2);
    check("R2", "reset wins ind", ind, 4'b0001);
    check("R2", "reset wins tx", tx_sel, 0);
    res_pin = 0; step(2);
    check("R3", "test wins over DT", tx_sel, 4);
    pulses = 0;
    for (int i = 0; i < 160; i++) begin step(1); pulses += line_pulse; end
    check("R3", "pulse count in 160 cycles", pulses, 10);
    ssp_pin = 0; step(2);
    check("R4", "DT pin transparent", ind, 4'b1100);
    dt_pin = 0; cmd = 4'b0101; step(2);
    check("R3", "SSP command test", tx_sel, 4);
    cmd = 4'b1001; step(2);
    check("R5", "AR1 leaves test", tx_sel, 0);

    // Constrained random
    for (int seg = 0; seg < 500; seg++) begin
      logic [3:0] pick [12] = '{4'b0000, 4'b0010, 4'b0101, 4'b0110, 4'b1000, 4'b1001,
                               4'b1010, 4'b1011, 4'b1101, 4'b1111, 4'b0010, 4'b1111};
      cmd      = pick[$urandom_range(0, 11)];
      res_pin  = ($urandom_range(0, 19) == 0);
      ssp_pin  = ($urandom_range(0, 19) == 0);
      dt_pin   = ($urandom_range(0, 19) == 0);
      awake_rx = $urandom_range(0, 1);
      sync_ok  = $urandom_range(0, 1);
      rt_sync  = $urandom_range(0, 1);
      step($urandom_range(1, 60));
      if (seg % 100 == 99) do_reset();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule